// File: doc/BRIEF.md
# Internal Data Memory Controller for an 8051-Compatible Core

This block is the on-chip operand store of an 8051-compatible processor. It keeps 256 bytes of internal RAM and a small file of special function registers (SFRs). It also turns each operand addressing mode into the right storage location. An execution unit presents one access per cycle. The access names a mode, an 8-bit address or register index, a write flag and write data. The response comes back on the following cycle.

Register operands are placed in one of four banks. The bank is chosen by two bits of the status word, which itself lives in the SFR file. The same upper half of the address space means two different things:

- A direct access to 0x80–0xFF reaches the SFRs.
- An indirect access through R0 or R1 to 0x80–0xFF reaches the upper 128 bytes of RAM.

Bit accesses address single bits. A bit write updates its containing byte in a single cycle: the byte is read, the chosen bit is replaced, and the byte is written back.

Top module: `idata_store`

## Requirements
- R1: After reset every RAM byte reads 0x00, the stack pointer SFR at direct address 0x81 reads 0x07, and every other implemented SFR reads 0x00.
- R2: Each cycle with `reqValid` high gives exactly one cycle of `rspValid` on the next cycle. No response appears otherwise. A write responds with `rspData` = 0x00.
- R3: Mode 0 (register) reaches RAM byte {2'b00... bank, n} = 8*bank + n. Here n is `reqAddr[2:0]` and bank is bits 4:3 of the status word SFR at 0xD0.
- R4: Mode 1 (direct) with an address from 0x00 to 0x7F reads and writes that RAM byte.
- R5: Mode 1 (direct) with an address from 0x80 to 0xFF reaches only the SFR file and never RAM.
- R6: Mode 2 (indirect) uses as its address the RAM byte held in R0 (`reqAddr[0]`=0) or R1 (`reqAddr[0]`=1) of the current bank. Any address from 0x00 to 0xFF reaches RAM, never an SFR.
- R7: Mode 3 (bit) with an address below 0x80 selects bit `reqAddr[2:0]` of RAM byte 0x20 + `reqAddr[6:3]`. A bit read returns that bit in `rspData[0]`, with bits 7:1 zero.
- R8: Mode 3 (bit) with an address of 0x80 or above selects bit `reqAddr[2:0]` of the SFR at {`reqAddr[7:3]`, 3'b000}.
- R9: A bit write stores `reqWdata[0]` into the selected bit and leaves the other seven bits of the byte unchanged.
- R10: The implemented SFRs are at 0x80, 0x81, 0x82, 0x83, 0x88, 0xA8, 0xB8, 0xD0, 0xE0 and 0xF0. A byte or bit access to any other SFR address reads 0x00 and its writes are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Access request this cycle |
| reqMode | input | 2 | 0 register, 1 direct, 2 indirect, 3 bit |
| reqAddr | input | 8 | Register index, byte address or bit address |
| reqWrite | input | 1 | 1 write, 0 read |
| reqWdata | input | 8 | Write byte; bit 0 is the value for bit writes |
| rspValid | output | 1 | Response valid, one cycle after the request |
| rspData | output | 8 | Read byte, read bit in bit 0, or 0x00 for writes |

## Verification
The same numeric address is driven in direct and indirect modes. A difference in the read value then shows whether the SFR space and upper RAM are kept apart. Register accesses are repeated after changing the bank bits, both by a byte write to the status word and by a bit write to it, and then cross-checked with direct reads of the expected RAM byte. Bit reads and writes are run against a RAM byte and an SFR that both hold known patterns, so a wrong byte, a wrong bit index or disturbed neighbouring bits each give a different readback. Accesses to an unimplemented SFR check that nothing is stored there and that no RAM byte is touched.

// File: rtl/idata_pkg.sv
package idata_pkg;

  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 8;
  localparam int RAM_SIZE = 1 << ADDR_W;
  localparam int BANK_W   = 2;
  localparam int NUM_SFR  = 10;

  localparam logic [ADDR_W-1:0] SP_ADDR  = 8'h81;
  localparam logic [ADDR_W-1:0] PSW_ADDR = 8'hD0;
  localparam logic [DATA_W-1:0] SP_INIT  = 8'h07;
  localparam int                BANK_LSB = 3;
  localparam logic [ADDR_W-1:0] BITRAM_BASE = 8'h20;

  typedef enum logic [1:0] {
    MODE_REG = 2'd0,
    MODE_DIR = 2'd1,
    MODE_IND = 2'd2,
    MODE_BIT = 2'd3
  } accMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              ramSel;
    logic              sfrSel;
    logic              usePtr;
    logic              ptrIdx;
    logic              isBit;
    logic              wr;
    logic [2:0]        bitIdx;
    logic [ADDR_W-1:0] immAddr;
    logic [DATA_W-1:0] wdata;
  } accCtl_t;

  function automatic logic [ADDR_W-1:0] sfrAddrOf(input int slot);
    case (slot)
      0: sfrAddrOf = 8'h80;
      1: sfrAddrOf = 8'h81;
      2: sfrAddrOf = 8'h82;
      3: sfrAddrOf = 8'h83;
      4: sfrAddrOf = 8'h88;
      5: sfrAddrOf = 8'hA8;
      6: sfrAddrOf = 8'hB8;
      7: sfrAddrOf = 8'hD0;
      8: sfrAddrOf = 8'hE0;
      default: sfrAddrOf = 8'hF0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] sfrInitOf(input int slot);
    sfrInitOf = (sfrAddrOf(slot) == SP_ADDR) ? SP_INIT : '0;
  endfunction

endpackage

// File: rtl/idata_ctrl.sv
module idata_ctrl
  import idata_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic [1:0]            reqMode,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic                  reqWrite,
  input  logic [DATA_W-1:0]     reqWdata,
  input  logic [BANK_W-1:0]     bank,
  output accCtl_t               ctl,
  output logic                  rspValid
);

  localparam int IDX_W = 3;

  accMode_e modeE;
  assign modeE = accMode_e'(reqMode);

  always_comb begin
    ctl         = '0;
    ctl.wdata   = reqWdata;
    ctl.wr      = reqValid & reqWrite;
    ctl.bitIdx  = reqAddr[IDX_W-1:0];
    if (reqValid) begin
      unique case (modeE)
        MODE_REG: begin
          ctl.ramSel  = 1'b1;
          ctl.immAddr = {{(ADDR_W-BANK_W-IDX_W){1'b0}}, bank, reqAddr[IDX_W-1:0]};
        end
        MODE_DIR: begin
          ctl.ramSel  = ~reqAddr[ADDR_W-1];
          ctl.sfrSel  = reqAddr[ADDR_W-1];
          ctl.immAddr = reqAddr;
        end
        MODE_IND: begin
          ctl.ramSel  = 1'b1;
          ctl.usePtr  = 1'b1;
          ctl.ptrIdx  = reqAddr[0];
        end
        MODE_BIT: begin
          ctl.isBit = 1'b1;
          if (reqAddr[ADDR_W-1]) begin
            ctl.sfrSel  = 1'b1;
            ctl.immAddr = {reqAddr[ADDR_W-1:IDX_W], {IDX_W{1'b0}}};
          end else begin
            ctl.ramSel  = 1'b1;
            ctl.immAddr = BITRAM_BASE + {{(IDX_W+1){1'b0}}, reqAddr[ADDR_W-2:IDX_W]};
          end
        end
        default: ctl = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= reqValid;
  end

endmodule

// File: rtl/idata_path.sv
module idata_path
  import idata_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  accCtl_t               ctl,
  output logic [BANK_W-1:0]     bank,
  output logic [DATA_W-1:0]     rspData
);

  logic [DATA_W-1:0] ram [RAM_SIZE];
  logic [DATA_W-1:0] sfrQ [NUM_SFR];
  logic [NUM_SFR-1:0] sfrHit;
  logic [ADDR_W-1:0] ptrAddr, ptrVal, effAddr;
  logic [DATA_W-1:0] sfrByte, curByte, newByte, rdOut;
  logic [DATA_W-1:0] pswByte;

  // bank select from the status word slot
  always_comb begin
    pswByte = '0;
    for (int i = 0; i < NUM_SFR; i++)
      if (sfrAddrOf(i) == PSW_ADDR) pswByte = sfrQ[i];
  end
  assign bank = pswByte[BANK_LSB +: BANK_W];

  // pointer register R0/R1 of the current bank
  assign ptrAddr = {{(ADDR_W-BANK_W-3){1'b0}}, bank, 2'b00, ctl.ptrIdx};
  assign ptrVal  = ram[ptrAddr];
  assign effAddr = ctl.usePtr ? ptrVal : ctl.immAddr;

  always_comb begin
    sfrByte = '0;
    for (int i = 0; i < NUM_SFR; i++)
      if (sfrHit[i]) sfrByte = sfrQ[i];
  end

  always_comb begin
    if (ctl.ramSel)      curByte = ram[effAddr];
    else if (ctl.sfrSel) curByte = sfrByte;
    else                 curByte = '0;
  end

  always_comb begin
    newByte = ctl.wdata;
    if (ctl.isBit) begin
      newByte = curByte;
      newByte[ctl.bitIdx] = ctl.wdata[0];
    end
  end

  assign rdOut = ctl.isBit ? {{(DATA_W-1){1'b0}}, curByte[ctl.bitIdx]} : curByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < RAM_SIZE; i++) ram[i] <= '0;
    end else if (ctl.ramSel && ctl.wr) begin
      ram[effAddr] <= newByte;
    end
  end

  for (genvar g = 0; g < NUM_SFR; g++) begin : gSfr
    localparam logic [ADDR_W-1:0] SLOT_ADDR = sfrAddrOf(g);
    localparam logic [DATA_W-1:0] SLOT_INIT = sfrInitOf(g);
    assign sfrHit[g] = ctl.sfrSel && (effAddr == SLOT_ADDR);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                    sfrQ[g] <= SLOT_INIT;
      else if (sfrHit[g] && ctl.wr) sfrQ[g] <= newByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       rspData <= '0;
    else if (ctl.wr) rspData <= '0;
    else             rspData <= rdOut;
  end

endmodule

// File: rtl/idata_store.sv
module idata_store
  import idata_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqMode,
  input  logic [7:0]        reqAddr,
  input  logic              reqWrite,
  input  logic [7:0]        reqWdata,
  output logic              rspValid,
  output logic [7:0]        rspData
);

  accCtl_t           ctl;
  logic [BANK_W-1:0] bank;

  idata_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqMode  (reqMode),
    .reqAddr  (reqAddr),
    .reqWrite (reqWrite),
    .reqWdata (reqWdata),
    .bank     (bank),
    .ctl      (ctl),
    .rspValid (rspValid)
  );

  idata_path u_path (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .bank    (bank),
    .rspData (rspData)
  );

endmodule

// File: rtl/idata_store_chk.sv
module idata_store_chk (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic [1:0] reqMode,
  input logic [7:0] reqAddr,
  input logic       reqWrite,
  input logic [7:0] rspData,
  input logic       rspValid
);

  a_r2_rsp_follows: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  a_r2_write_zero: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite) |=> (rspData == 8'h00));

  a_r7_bit_single: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && reqMode == 2'd3) |=> (rspData[7:1] == 7'd0));

  a_r10_unimpl_zero: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && reqMode == 2'd1 && reqAddr == 8'h90) |=> (rspData == 8'h00));

  a_r10_unimpl_bit_zero: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && reqMode == 2'd3 && reqAddr[7:3] == 5'b10010) |=> (rspData == 8'h00));

endmodule

bind idata_store idata_store_chk u_chk (.*);

// File: tb/idata_store_bench.sv
module idata_store_bench;

  localparam logic [1:0] M_REG = 2'd0, M_DIR = 2'd1, M_IND = 2'd2, M_BIT = 2'd3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic [1:0] reqMode = '0;
  logic [7:0] reqAddr = '0;
  logic       reqWrite = 1'b0;
  logic [7:0] reqWdata = '0;
  logic       rspValid;
  logic [7:0] rspData;

  int checks = 0;
  int errors = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];

  always #10 clk = ~clk;

  idata_store u_idata_store (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqMode(reqMode),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData)
  );

  task automatic acc(input logic [1:0] m, input logic [7:0] a, input logic w,
                     input logic [7:0] d, input logic [7:0] e, input string tag);
    @(negedge clk);
    reqValid = 1'b1; reqMode = m; reqAddr = a; reqWrite = w; reqWdata = d;
    expQ.push_back(w ? 8'h00 : e);
    tagQ.push_back(w ? "R2" : tag);
  endtask

  // monitor: pops one expected item per response
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected response actual %02h expected none", rspData);
      end else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (rspData !== e) begin
          errors++;
          $display("FAIL %s actual %02h expected %02h", t, rspData, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rspValid !== 1'b0) begin
      errors++;
      $display("FAIL R2 reset actual %b expected 0", rspValid);
    end
    rstN = 1'b1;
    // R1 reset state
    acc(M_DIR, 8'h81, 0, 0, 8'h07, "R1");
    acc(M_DIR, 8'hD0, 0, 0, 8'h00, "R1");
    acc(M_DIR, 8'h30, 0, 0, 8'h00, "R1");
    acc(M_IND, 8'h00, 0, 0, 8'h00, "R1");
    // R3 register banks
    acc(M_REG, 8'h03, 1, 8'h11, 0, "R3");
    acc(M_DIR, 8'h03, 0, 0, 8'h11, "R3");
    acc(M_DIR, 8'hD0, 1, 8'h18, 0, "R3");
    acc(M_REG, 8'h03, 1, 8'h33, 0, "R3");
    acc(M_DIR, 8'h1B, 0, 0, 8'h33, "R3");
    acc(M_REG, 8'h03, 0, 0, 8'h33, "R3");
    acc(M_DIR, 8'hD0, 1, 8'h00, 0, "R3");
    acc(M_REG, 8'h03, 0, 0, 8'h11, "R3");
    // R4 direct lower RAM
    acc(M_DIR, 8'h7F, 1, 8'h5A, 0, "R4");
    acc(M_DIR, 8'h7F, 0, 0, 8'h5A, "R4");
    // R5 / R6 direct vs indirect upper half
    acc(M_DIR, 8'h81, 1, 8'h55, 0, "R5");
    acc(M_REG, 8'h00, 1, 8'h81, 0, "R6");
    acc(M_IND, 8'h00, 0, 0, 8'h00, "R6");
    acc(M_IND, 8'h00, 1, 8'hAA, 0, "R6");
    acc(M_IND, 8'h00, 0, 0, 8'hAA, "R6");
    acc(M_DIR, 8'h81, 0, 0, 8'h55, "R5");
    acc(M_REG, 8'h01, 1, 8'h7F, 0, "R6");
    acc(M_IND, 8'h01, 0, 0, 8'h5A, "R6");
    acc(M_DIR, 8'hD0, 1, 8'h10, 0, "R6");
    acc(M_IND, 8'h00, 0, 0, 8'h81, "R6");
    acc(M_DIR, 8'hD0, 1, 8'h00, 0, "R6");
    // R7 / R9 bit RAM area
    acc(M_DIR, 8'h25, 1, 8'hA5, 0, "R7");
    acc(M_BIT, 8'h28, 0, 0, 8'h01, "R7");
    acc(M_BIT, 8'h29, 0, 0, 8'h00, "R7");
    acc(M_BIT, 8'h2F, 0, 0, 8'h01, "R7");
    acc(M_BIT, 8'h29, 1, 8'h01, 0, "R9");
    acc(M_DIR, 8'h25, 0, 0, 8'hA7, "R9");
    acc(M_BIT, 8'h2F, 1, 8'hFE, 0, "R9");
    acc(M_DIR, 8'h25, 0, 0, 8'h27, "R9");
    // R8 bit SFR area
    acc(M_DIR, 8'hE0, 1, 8'h0F, 0, "R8");
    acc(M_BIT, 8'hE3, 0, 0, 8'h01, "R8");
    acc(M_BIT, 8'hE4, 0, 0, 8'h00, "R8");
    acc(M_BIT, 8'hE7, 1, 8'h01, 0, "R8");
    acc(M_DIR, 8'hE0, 0, 0, 8'h8F, "R8");
    acc(M_DIR, 8'h0B, 1, 8'h77, 0, "R8");
    acc(M_BIT, 8'hD3, 1, 8'h01, 0, "R8");
    acc(M_DIR, 8'hD0, 0, 0, 8'h08, "R8");
    acc(M_REG, 8'h03, 0, 0, 8'h77, "R3");
    acc(M_DIR, 8'hD0, 1, 8'h00, 0, "R8");
    // R10 unimplemented SFR
    acc(M_DIR, 8'h90, 1, 8'h12, 0, "R10");
    acc(M_DIR, 8'h90, 0, 0, 8'h00, "R10");
    acc(M_BIT, 8'h91, 1, 8'h01, 0, "R10");
    acc(M_BIT, 8'h91, 0, 0, 8'h00, "R10");
    acc(M_DIR, 8'h90, 0, 0, 8'h00, "R10");
    acc(M_DIR, 8'h22, 0, 0, 8'h00, "R10");
    acc(M_IND, 8'h00, 0, 0, 8'hAA, "R10");
    @(negedge clk);
    reqValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    checks++;
    if (rspValid !== 1'b0) begin
      errors++;
      $display("FAIL R2 idle actual %b expected 0", rspValid);
    end
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R2 missing responses actual %0d expected 0", expQ.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule